// File: doc/BRIEF.md
# Extended-Precision to IEEE Store Converter

This unit turns an 80-bit extended-precision floating-point operand into an IEEE single or IEEE double bit pattern, ready for a store. The operand has a sign at bit 79, a 15-bit biased exponent at bits 78:64 and a 64-bit significand with an explicit integer bit at bit 63. The unit also builds the 16-bit floating-point status word that the store instruction leaves behind. It classifies the operand and rounds it in the selected direction. It handles overflow, underflow and denormalisation. It maps NaNs and illegal encodings, and it raises exception flags according to the mask bits. When an exception is unmasked, the unit withholds the store and reports only the status.

The unit has one register stage. An operand presented with `in_valid` in cycle N produces `out_valid`, `store_en`, `result` and `fsw_out` after the clock edge that ends cycle N. The format is chosen per operation with `dbl_sel`. Register-stack handling, trap delivery and the memory write itself stay with the surrounding pipeline.

Top module: `fpst_store_cvt`

## Requirements
- R1: The status word `fsw_out` is built as follows. Bits 13:11 are 7. C0 (bit 8), C2 (bit 10) and C3 (bit 14) copy `cond_in[0]`, `cond_in[1]` and `cond_in[2]`. Bit 15 always equals ES (bit 7). Bits 6, 2 and 1 are 0. All other flags start clear and are set only by the rules below: IE is bit 0, OE bit 3, UE bit 4, PE bit 5 and C1 bit 9.
- R2: `out_valid` follows `in_valid` one cycle later. With `dbl_sel`=1 the result is an IEEE double on `result[63:0]`. With `dbl_sel`=0 it is an IEEE single on `result[31:0]` and bits 63:32 are zero. `result` is zero whenever `store_en` is low.
- R3: `rnd_mode` selects the rounding direction: 00 is nearest with ties to even, 01 is toward minus infinity, 10 is toward plus infinity and 11 is toward zero. Any discarded nonzero bits set PE. C1 is set when the stored magnitude was rounded up. ES is set when PE is set and the precision mask `exc_mask[3]` is 0; the store still happens.
- R4: When rounding carries out of the kept significand, the exponent goes up by one and the fraction becomes zero.
- R5: Overflow occurs when the output exponent reaches the all-ones value, either directly or through rounding, and it sets OE. With `exc_mask[1]`=0, ES is set and the store is suppressed. With `exc_mask[1]`=1, the unit stores signed infinity for nearest rounding and for rounding toward the sign's infinity, and the largest finite magnitude otherwise. PE, C1 and ES then follow R3, with C1 set only for the infinity case.
- R6: A tiny normal operand (biased output exponent below 1 that does not round up to the smallest normal) with `exc_mask[2]`=0 sets UE and ES and suppresses the store.
- R7: With `exc_mask[2]`=1, a tiny operand is denormalised with a sticky bit and then rounded. It may round up to the smallest normal. UE is set only when the result is inexact.
- R8: Zero and infinity (integer bit set, fraction zero) are stored with their sign and raise no flag.
- R9: A NaN operand keeps its sign and its upper fraction bits, and its quiet bit is forced to 1; the indefinite encoding stores a NaN with only the quiet bit set. A signalling NaN (bit 62 clear) sets IE. When `exc_mask[0]`=0 it also sets ES and suppresses the store.
- R10: An operand with exponent nonzero and integer bit 0 (pseudo-infinity, pseudo-NaN or unnormal) sets IE. With `exc_mask[0]`=1 it stores a negative NaN with only the quiet bit set; with `exc_mask[0]`=0 it sets ES and suppresses the store.
- R11: An operand with exponent 0 and a nonzero significand sets UE. With `exc_mask[2]`=1 it stores a signed zero and sets PE; when rounding toward the sign's infinity it stores the smallest subnormal instead and also sets C1. ES follows the precision mask. With `exc_mask[2]`=0 the unit sets ES and suppresses the store.
- R12: While `rst` is high at a clock edge, `out_valid`, `store_en`, `result` and `fsw_out` are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand and controls valid this cycle |
| dbl_sel | input | 1 | 1 selects double output, 0 selects single |
| operand | input | 80 | Extended-precision source value |
| rnd_mode | input | 2 | Rounding direction |
| exc_mask | input | 4 | Masks: [0] invalid, [1] overflow, [2] underflow, [3] precision |
| cond_in | input | 3 | Incoming condition bits {C3, C2, C0} |
| out_valid | output | 1 | Result and status valid |
| store_en | output | 1 | Store may be performed |
| result | output | 64 | Packed IEEE result |
| fsw_out | output | 16 | Updated status word |

## Verification
Some properties hold on every cycle, and the bound checker watches them: the fixed TOP field, the busy bit tracking ES, the condition bits copied through, and one-cycle validity. It also checks that a withheld store always carries ES with a zero result, that single results keep the upper half clear, that C1 never appears without PE, and that a stored double NaN is always quiet. The exact rounded values need the scenarios, as do ties to even, the choice between infinity and the largest finite value on overflow, denormalisation with sticky bits and the tininess boundary at exponent zero. For these the bench compares every output against an exact-integer model that rounds at the final bit position.

// File: rtl/fpst_pkg.sv
package fpst_pkg;

  // rounding direction codes
  localparam logic [1:0] RM_NEAR = 2'b00;
  localparam logic [1:0] RM_DOWN = 2'b01;
  localparam logic [1:0] RM_UP   = 2'b10;
  localparam logic [1:0] RM_TRNC = 2'b11;

  // mask bit positions inside exc_mask
  localparam int MK_INV = 0;
  localparam int MK_OVF = 1;
  localparam int MK_UNF = 2;
  localparam int MK_PRE = 3;

  localparam int SRC_EXP_W  = 15;
  localparam int SRC_SIG_W  = 64;
  localparam int SRC_BIAS   = 16383;

  typedef enum logic [2:0] {
    CLS_ZERO,
    CLS_DENORM,
    CLS_NORMAL,
    CLS_INF,
    CLS_NAN,
    CLS_BADENC
  } cls_e;

  typedef struct packed {
    logic ie;
    logic oe;
    logic ue;
    logic pe;
    logic c1;
    logic es;
  } flags_t;

  // toward the infinity that carries the operand's sign
  function automatic logic toward_sign_inf(input logic [1:0] rm, input logic sgn);
    return (rm == RM_UP && !sgn) || (rm == RM_DOWN && sgn);
  endfunction

  // assemble the outgoing status word; cond = {C3, C2, C0}
  function automatic logic [15:0] build_fsw(input flags_t f, input logic [2:0] cond);
    return {f.es, cond[2], 3'b111, cond[1], f.c1, cond[0],
            f.es, 1'b0, f.pe, f.ue, f.oe, 2'b00, f.ie};
  endfunction

endpackage

// File: rtl/fpst_classify.sv
module fpst_classify
  import fpst_pkg::*;
(
  input  logic [SRC_EXP_W+SRC_SIG_W-1:0] enc,
  output cls_e                           cls
);
  localparam int SIG_W = SRC_SIG_W;

  logic [SRC_EXP_W-1:0] ex;
  logic [SIG_W-1:0]     sg;
  logic                 ex_zero;
  logic                 ex_full;

  assign ex      = enc[SRC_EXP_W+SIG_W-1:SIG_W];
  assign sg      = enc[SIG_W-1:0];
  assign ex_zero = (ex == '0);
  assign ex_full = (ex == '1);

  always_comb begin
    if (ex_zero) begin
      cls = (sg == '0) ? CLS_ZERO : CLS_DENORM;
    end else if (!sg[SIG_W-1]) begin
      cls = CLS_BADENC;
    end else if (ex_full) begin
      cls = (sg[SIG_W-2:0] == '0) ? CLS_INF : CLS_NAN;
    end else begin
      cls = CLS_NORMAL;
    end
  end

endmodule

// File: rtl/fpst_round.sv
module fpst_round
  import fpst_pkg::*;
#(
  parameter int FRAC_W = 52,
  parameter int EXP_W  = 11
) (
  input  logic                   sign,
  input  logic [SRC_EXP_W-1:0]   exp_in,
  input  logic [SRC_SIG_W-1:0]   mant,
  input  logic [1:0]             rnd_mode,
  input  logic [3:0]             exc_mask,
  output logic [FRAC_W+EXP_W:0]  value,
  output flags_t                 flags,
  output logic                   store_ok
);
  localparam int DROP = SRC_SIG_W - 1 - FRAC_W;
  localparam int KEEP = FRAC_W + 1;
  localparam int EMAX = (1 << EXP_W) - 1;
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam logic signed [19:0] EMAX_S = 20'(EMAX);
  localparam logic signed [19:0] ADJ    = 20'(BIAS - SRC_BIAS);
  localparam logic [DROP-1:0]    HALF   = {1'b1, {(DROP-1){1'b0}}};
  localparam logic signed [19:0] DEEP   = -20'sd63;

  logic signed [19:0] e_out;
  logic               nearest, twd, inc_nz;
  logic               lc0, wide_carry, tiny, uf, ovf;
  logic [6:0]         sh;
  logic [63:0]        lost, den, mw;
  logic [DROP-1:0]    roff;
  logic               lc, carry, tie, inexact, rounded_up;
  logic [KEEP:0]      hi_sum;
  logic [KEEP-1:0]    hi_fix, kept;
  logic [EXP_W-1:0]   exp_field;

  assign e_out   = $signed({5'b0, exp_in}) + ADJ;
  assign nearest = (rnd_mode == RM_NEAR);
  assign twd     = toward_sign_inf(rnd_mode, sign);
  assign inc_nz  = nearest || twd;

  // would the undenormalised significand round past all ones?
  assign lc0        = nearest ? mant[DROP-1] : (twd && (mant[DROP-1:0] != '0));
  assign wide_carry = (&mant[63:DROP]) && lc0;
  assign uf         = (e_out <= 0);
  assign tiny       = (e_out < 0) || !wide_carry;
  assign ovf        = !uf && ((e_out >= EMAX_S) || ((e_out == EMAX_S - 1) && wide_carry));

  // denormalise with sticky
  assign sh = 7'd1 - e_out[6:0];
  always_comb begin
    lost = '0;
    if (e_out <= DEEP) begin
      den = {63'b0, |mant};
    end else begin
      lost = mant & ((64'd1 << sh) - 64'd1);
      den  = (mant >> sh) | {63'b0, |lost};
    end
  end

  assign mw      = uf ? den : mant;
  assign roff    = mw[DROP-1:0];
  assign inexact = (roff != '0);
  assign lc      = nearest ? roff[DROP-1] : (twd && inexact);
  assign hi_sum  = {1'b0, mw[63:DROP]} + {{KEEP{1'b0}}, lc};
  assign carry   = hi_sum[KEEP];
  assign tie     = nearest && (roff == HALF);
  assign hi_fix  = {hi_sum[KEEP-1:1], hi_sum[0] & ~tie};
  assign kept    = carry ? {1'b1, hi_fix[KEEP-1:1]} : hi_fix;
  assign rounded_up = carry || (hi_fix != mw[63:DROP]);

  always_comb begin
    if (uf) exp_field = kept[FRAC_W] ? EXP_W'(1) : '0;
    else    exp_field = e_out[EXP_W-1:0] + EXP_W'(carry);
  end

  always_comb begin
    flags    = '0;
    store_ok = 1'b1;
    value    = {sign, exp_field, kept[FRAC_W-1:0]};
    if (uf && !exc_mask[MK_UNF] && tiny) begin
      flags.ue = 1'b1;
      flags.es = 1'b1;
      store_ok = 1'b0;
      value    = '0;
    end else if (ovf) begin
      flags.oe = 1'b1;
      if (!exc_mask[MK_OVF]) begin
        flags.es = 1'b1;
        store_ok = 1'b0;
        value    = '0;
      end else begin
        if (inexact) begin
          flags.pe = 1'b1;
          flags.c1 = inc_nz;
          flags.es = !exc_mask[MK_PRE];
        end
        if (inc_nz) value = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        else        value = {sign, {{(EXP_W-1){1'b1}}, 1'b0}, {FRAC_W{1'b1}}};
      end
    end else begin
      flags.pe = inexact;
      flags.c1 = inexact && rounded_up;
      flags.ue = uf && inexact && tiny;
      flags.es = inexact && !exc_mask[MK_PRE];
    end
  end

endmodule

// File: rtl/fpst_format.sv
module fpst_format
  import fpst_pkg::*;
#(
  parameter int FRAC_W = 52,
  parameter int EXP_W  = 11
) (
  input  cls_e                   cls,
  input  logic                   sign,
  input  logic [SRC_EXP_W-1:0]   exp_in,
  input  logic [SRC_SIG_W-1:0]   mant,
  input  logic [1:0]             rnd_mode,
  input  logic [3:0]             exc_mask,
  output logic [FRAC_W+EXP_W:0]  value,
  output flags_t                 flags,
  output logic                   store_ok
);
  localparam logic [FRAC_W-1:0] QBIT = {1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic [EXP_W-1:0]  EALL = '1;

  logic [FRAC_W+EXP_W:0] nrm_value;
  flags_t                nrm_flags;
  logic                  nrm_ok;
  logic                  snan, twd;

  fpst_round #(.FRAC_W(FRAC_W), .EXP_W(EXP_W)) u_round (
    .sign     (sign),
    .exp_in   (exp_in),
    .mant     (mant),
    .rnd_mode (rnd_mode),
    .exc_mask (exc_mask),
    .value    (nrm_value),
    .flags    (nrm_flags),
    .store_ok (nrm_ok)
  );

  assign snan = !mant[SRC_SIG_W-2];
  assign twd  = toward_sign_inf(rnd_mode, sign);

  always_comb begin
    flags    = '0;
    store_ok = 1'b1;
    value    = '0;
    unique case (cls)
      CLS_ZERO: value = {sign, {(EXP_W+FRAC_W){1'b0}}};
      CLS_INF:  value = {sign, EALL, {FRAC_W{1'b0}}};
      CLS_NAN: begin
        flags.ie = snan;
        if (snan && !exc_mask[MK_INV]) begin
          flags.es = 1'b1;
          store_ok = 1'b0;
        end else begin
          value = {sign, EALL, mant[SRC_SIG_W-2 -: FRAC_W] | QBIT};
        end
      end
      CLS_BADENC: begin
        flags.ie = 1'b1;
        if (exc_mask[MK_INV]) begin
          value = {1'b1, EALL, QBIT};
        end else begin
          flags.es = 1'b1;
          store_ok = 1'b0;
        end
      end
      CLS_DENORM: begin
        flags.ue = 1'b1;
        if (exc_mask[MK_UNF]) begin
          flags.pe = 1'b1;
          flags.c1 = twd;
          flags.es = !exc_mask[MK_PRE];
          value    = {sign, {EXP_W{1'b0}}, {{(FRAC_W-1){1'b0}}, twd}};
        end else begin
          flags.es = 1'b1;
          store_ok = 1'b0;
        end
      end
      default: begin
        value    = nrm_value;
        flags    = nrm_flags;
        store_ok = nrm_ok;
      end
    endcase
  end

endmodule

// File: rtl/fpst_store_cvt.sv
module fpst_store_cvt
  import fpst_pkg::*;
#(
  parameter int SGL_FRAC_W = 23,
  parameter int SGL_EXP_W  = 8,
  parameter int DBL_FRAC_W = 52,
  parameter int DBL_EXP_W  = 11,
  parameter int RES_W      = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             dbl_sel,
  input  logic [79:0]      operand,
  input  logic [1:0]       rnd_mode,
  input  logic [3:0]       exc_mask,
  input  logic [2:0]       cond_in,
  output logic             out_valid,
  output logic             store_en,
  output logic [RES_W-1:0] result,
  output logic [15:0]      fsw_out
);
  localparam int NFMT = 2;

  cls_e              cls;
  logic [RES_W-1:0]  fmt_val [NFMT];
  flags_t            fmt_flg [NFMT];
  logic              fmt_ok  [NFMT];
  logic              sel;

  fpst_classify u_cls (
    .enc (operand[78:0]),
    .cls (cls)
  );

  for (genvar g = 0; g < NFMT; g++) begin : g_fmt
    localparam int FW = (g == 0) ? SGL_FRAC_W : DBL_FRAC_W;
    localparam int EW = (g == 0) ? SGL_EXP_W  : DBL_EXP_W;
    logic [FW+EW:0] val;
    fpst_format #(.FRAC_W(FW), .EXP_W(EW)) u_fmt (
      .cls      (cls),
      .sign     (operand[79]),
      .exp_in   (operand[78:64]),
      .mant     (operand[63:0]),
      .rnd_mode (rnd_mode),
      .exc_mask (exc_mask),
      .value    (val),
      .flags    (fmt_flg[g]),
      .store_ok (fmt_ok[g])
    );
    assign fmt_val[g] = RES_W'(val);
  end

  assign sel = dbl_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      store_en  <= 1'b0;
      result    <= '0;
      fsw_out   <= '0;
    end else begin
      out_valid <= in_valid;
      store_en  <= in_valid && fmt_ok[sel];
      if (in_valid) begin
        result  <= fmt_ok[sel] ? fmt_val[sel] : '0;
        fsw_out <= build_fsw(fmt_flg[sel], cond_in);
      end
    end
  end

endmodule

// File: rtl/fpst_store_cvt_chk.sv
module fpst_store_cvt_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        dbl_sel,
  input logic [2:0]  cond_in,
  input logic        out_valid,
  input logic        store_en,
  input logic [63:0] result,
  input logic [15:0] fsw_out
);

  p_top_seven_r1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> fsw_out[13:11] == 3'b111);

  p_busy_tracks_es_r1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> fsw_out[15] == fsw_out[7]);

  p_cond_copy_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> {fsw_out[14], fsw_out[10], fsw_out[8]} == $past(cond_in));

  p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_idle_follow_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid && !store_en);

  p_withheld_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !store_en) |-> (result == 64'd0) && fsw_out[7]);

  p_single_upper_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !dbl_sel) |=> result[63:32] == 32'd0);

  p_c1_needs_pe_r3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && fsw_out[9]) |-> fsw_out[5]);

  p_nan_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dbl_sel) |=>
      !(store_en && result[62:52] == 11'h7ff && result[51:0] != 52'd0) || result[51]);

endmodule

bind fpst_store_cvt fpst_store_cvt_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .dbl_sel   (dbl_sel),
  .cond_in   (cond_in),
  .out_valid (out_valid),
  .store_en  (store_en),
  .result    (result),
  .fsw_out   (fsw_out)
);

// File: tb/fpst_store_cvt_test.sv
module fpst_store_cvt_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        dbl_sel = 1'b0;
  logic [79:0] operand = '0;
  logic [1:0]  rnd_mode = '0;
  logic [3:0]  exc_mask = '0;
  logic [2:0]  cond_in = '0;
  logic        out_valid, store_en;
  logic [63:0] result;
  logic [15:0] fsw_out;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  fpst_store_cvt uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .dbl_sel(dbl_sel),
    .operand(operand), .rnd_mode(rnd_mode), .exc_mask(exc_mask),
    .cond_in(cond_in), .out_valid(out_valid), .store_en(store_en),
    .result(result), .fsw_out(fsw_out)
  );

  typedef struct {
    logic        st;
    logic [63:0] res;
    logic [15:0] fsw;
    string       tag;
  } exp_t;

  exp_t sb[$];

  localparam logic [63:0] ONE = 64'h8000_0000_0000_0000;

  task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [79:0] mkop(input logic s, input int eo, input logic dbl, input logic [63:0] m);
    int e80;
    e80 = eo + 16383 - (dbl ? 1023 : 127);
    return {s, e80[14:0], m};
  endfunction

  function automatic logic rnd_up(input logic near, input logic twd, input logic [127:0] rem,
                                  input logic [127:0] half, input logic lsb);
    if (near) return (rem > half) || (rem == half && lsb);
    return twd && (rem != 128'd0);
  endfunction

  // exact-integer reference of the store conversion
  function automatic exp_t model(input logic [79:0] op, input logic [1:0] rc, input logic [3:0] mk,
                                 input logic dbl, input logic [2:0] cc, input string tag);
    exp_t r;
    int fw, ew, emax, bias, drop, eo, s;
    logic sg, im, om, um, pm, twd, near;
    logic ie, oe, ue, pe, c1, es, st, tiny, upu, ovr, up;
    logic [14:0] e;
    logic [63:0] m, hi, rem, half, q2, frac, expf, allk;
    logic [127:0] qw, rw, hw;
    fw = dbl ? 52 : 23; ew = dbl ? 11 : 8;
    emax = (1 << ew) - 1; bias = (1 << (ew - 1)) - 1; drop = 63 - fw;
    sg = op[79]; e = op[78:64]; m = op[63:0];
    im = mk[0]; om = mk[1]; um = mk[2]; pm = mk[3];
    near = (rc == 2'b00);
    twd  = (rc == 2'b10 && !sg) || (rc == 2'b01 && sg);
    {ie, oe, ue, pe, c1, es} = '0; st = 1'b1;
    expf = '0; frac = '0;
    if (e == 15'd0) begin
      if (m != 64'd0) begin
        ue = 1;
        if (um) begin pe = 1; c1 = twd; es = !pm; frac = {63'd0, twd}; end
        else begin es = 1; st = 0; end
      end
    end else if (!m[63]) begin
      ie = 1;
      if (im) begin sg = 1; expf = 64'(emax); frac = 64'd1 << (fw - 1); end
      else begin es = 1; st = 0; end
    end else if (e == 15'h7fff) begin
      expf = 64'(emax);
      if (m[62:0] != 63'd0) begin
        ie = !m[62];
        if (!m[62] && !im) begin es = 1; st = 0; end
        else frac = ({1'b0, m[62:0]} >> (63 - fw)) | (64'd1 << (fw - 1));
      end
    end else begin
      eo   = int'(e) - 16383 + bias;
      hi   = m >> drop;
      rem  = m & ((64'd1 << drop) - 64'd1);
      half = 64'd1 << (drop - 1);
      allk = (64'd1 << (fw + 1)) - 64'd1;
      upu  = rnd_up(near, twd, {64'd0, rem}, {64'd0, half}, hi[0]);
      ovr  = upu && (hi == allk);
      if (eo <= 0) begin
        tiny = (eo < 0) || !ovr;
        if (!um && tiny) begin ue = 1; es = 1; st = 0; end
        else begin
          s = drop + 1 - eo;
          if (s > 127) s = 127;
          qw = {64'd0, m} >> s;
          rw = {64'd0, m} & ((128'd1 << s) - 128'd1);
          hw = 128'd1 << (s - 1);
          up = rnd_up(near, twd, rw, hw, qw[0]);
          q2 = qw[63:0] + 64'(up);
          pe = (rw != 128'd0); ue = pe && tiny; c1 = up; es = pe && !pm;
          expf = q2[fw] ? 64'd1 : 64'd0; frac = q2;
        end
      end else if (eo >= emax || (eo == emax - 1 && ovr)) begin
        oe = 1;
        if (!om) begin es = 1; st = 0; end
        else begin
          if (rem != 64'd0) begin pe = 1; c1 = near || twd; es = !pm; end
          if (near || twd) begin expf = 64'(emax); frac = '0; end
          else begin expf = 64'(emax - 1); frac = '1; end
        end
      end else begin
        q2 = hi + 64'(upu); expf = 64'(eo);
        if ((q2 >> (fw + 1)) != 64'd0) begin q2 = q2 >> 1; expf = expf + 64'd1; end
        frac = q2; pe = (rem != 64'd0); c1 = upu; es = pe && !pm;
      end
    end
    r.st  = st;
    r.tag = tag;
    if (!st) r.res = '0;
    else if (dbl) r.res = {sg, expf[10:0], frac[51:0]};
    else r.res = {32'd0, sg, expf[7:0], frac[22:0]};
    r.fsw = {es, cc[2], 3'b111, cc[1], c1, cc[0], es, 1'b0, pe, ue, oe, 2'b00, ie};
    return r;
  endfunction

  task automatic send(input logic [79:0] op, input logic [1:0] rc, input logic [3:0] mk,
                      input logic dbl, input logic [2:0] cc, input string tag);
    @(negedge clk);
    in_valid = 1'b1; operand = op; rnd_mode = rc; exc_mask = mk; dbl_sel = dbl; cond_in = cc;
    sb.push_back(model(op, rc, mk, dbl, cc, tag));
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (sb.size() == 0) begin
        check("R2", "unexpected_valid", 64'd1, 64'd0);
      end else begin
        exp_t x;
        x = sb.pop_front();
        check(x.tag, "store_en", {63'd0, store_en}, {63'd0, x.st});
        check(x.tag, "result", result, x.res);
        check(x.tag, "fsw", {48'd0, fsw_out}, {48'd0, x.fsw});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset clears all outputs
    check("R12", "reset_out", {out_valid, store_en, fsw_out, result[45:0]}, 64'd0);
    check("R12", "reset_res", result, 64'd0);
    rst = 1'b0;

    // R1 condition bits and TOP; R2 both formats
    send(mkop(0, 0, 1, ONE), 2'b00, 4'hf, 1, 3'b111, "R1");
    send(mkop(0, 0, 1, ONE), 2'b00, 4'hf, 1, 3'b010, "R1");
    send(mkop(1, 5, 0, ONE), 2'b00, 4'hf, 0, 3'b101, "R2");
    send(mkop(0, 200, 1, 64'hC000_0000_0000_0000), 2'b11, 4'hf, 1, 3'b000, "R2");
    // R3 ties to even, each direction, precision mask clear
    for (int rc = 0; rc < 4; rc++) begin
      send(mkop(0, 10, 1, ONE | 64'h400), 2'(rc), 4'h7, 1, 3'b000, "R3");
      send(mkop(1, 10, 1, ONE | 64'hC00), 2'(rc), 4'hf, 1, 3'b000, "R3");
      send(mkop(0, 10, 0, ONE | 64'h80_0000_0000), 2'(rc), 4'hf, 0, 3'b000, "R3");
      send(mkop(1, 10, 0, ONE | 64'h1_0000_0001), 2'(rc), 4'hf, 0, 3'b000, "R3");
    end
    // R4 carry out of the significand
    send(mkop(0, 3, 1, 64'hFFFF_FFFF_FFFF_FFFF), 2'b00, 4'hf, 1, 3'b000, "R4");
    send(mkop(1, 3, 0, 64'hFFFF_FFFF_FFFF_FFFF), 2'b01, 4'hf, 0, 3'b000, "R4");
    // R5 overflow
    for (int rc = 0; rc < 4; rc++) begin
      send(mkop(0, 2047, 1, ONE | 64'h1), 2'(rc), 4'hf, 1, 3'b000, "R5");
      send(mkop(1, 255, 0, ONE), 2'(rc), 4'hf, 0, 3'b000, "R5");
      send(mkop(0, 2046, 1, 64'hFFFF_FFFF_FFFF_FFFF), 2'(rc), 4'hd, 1, 3'b000, "R5");
    end
    send(mkop(0, 300, 0, ONE), 2'b00, 4'hd, 0, 3'b000, "R5");
    // R6 unmasked underflow, and the exponent-zero boundary
    send(mkop(0, -5, 1, ONE), 2'b00, 4'hb, 1, 3'b000, "R6");
    send(mkop(0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF), 2'b00, 4'hb, 0, 3'b000, "R6");
    send(mkop(0, 0, 0, 64'hFFFF_FF00_0000_0000), 2'b00, 4'hb, 0, 3'b000, "R6");
    // R7 masked underflow
    for (int rc = 0; rc < 4; rc++) begin
      send(mkop(0, -3, 1, ONE | 64'h3), 2'(rc), 4'hf, 1, 3'b000, "R7");
      send(mkop(1, -52, 1, ONE), 2'(rc), 4'hf, 1, 3'b000, "R7");
      send(mkop(0, -200, 0, ONE), 2'(rc), 4'h7, 0, 3'b000, "R7");
      send(mkop(1, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF), 2'(rc), 4'hf, 0, 3'b000, "R7");
    end
    send(mkop(0, -10, 1, ONE), 2'b00, 4'hf, 1, 3'b000, "R7");
    // R8 zero and infinity
    send({1'b1, 15'd0, 64'd0}, 2'b00, 4'h0, 1, 3'b000, "R8");
    send({1'b0, 15'h7fff, ONE}, 2'b01, 4'h0, 0, 3'b000, "R8");
    // R9 NaNs
    send({1'b0, 15'h7fff, 64'hC123_4567_89AB_CDEF}, 2'b00, 4'h0, 1, 3'b000, "R9");
    send({1'b1, 15'h7fff, 64'h8123_4567_89AB_CDEF}, 2'b00, 4'h1, 0, 3'b000, "R9");
    send({1'b1, 15'h7fff, 64'h8000_0000_0000_0001}, 2'b00, 4'h0, 1, 3'b000, "R9");
    send({1'b1, 15'h7fff, 64'hC000_0000_0000_0000}, 2'b00, 4'h0, 1, 3'b000, "R9");
    // R10 illegal encodings
    send({1'b0, 15'h7fff, 64'd0}, 2'b00, 4'h1, 1, 3'b000, "R10");
    send({1'b0, 15'h7fff, 64'h4000_0000_0000_0000}, 2'b00, 4'h0, 0, 3'b000, "R10");
    send({1'b0, 15'h3fff, 64'h7000_0000_0000_0000}, 2'b00, 4'h1, 0, 3'b000, "R10");
    // R11 denormal and pseudo-denormal inputs
    for (int rc = 0; rc < 4; rc++) begin
      send({1'b0, 15'd0, 64'h0000_0000_0000_0001}, 2'(rc), 4'hf, 1, 3'b000, "R11");
      send({1'b1, 15'd0, ONE}, 2'(rc), 4'h7, 0, 3'b000, "R11");
    end
    send({1'b0, 15'd0, 64'h1}, 2'b00, 4'hb, 1, 3'b000, "R11");

    // mixed sweep near every boundary, both formats, all directions
    for (int i = 0; i < 3000; i++) begin
      logic dbl;
      logic [63:0] m;
      int eo, em, pick;
      dbl = 1'($urandom);
      em = dbl ? 2047 : 255;
      pick = int'($urandom % 4);
      m = {1'b1, 31'($urandom), 32'($urandom)};
      if (($urandom % 3) == 0) m = m | (dbl ? 64'h7ff : 64'hFF_FFFF_FFFF);
      if (($urandom % 4) == 0) m = (m & ~(dbl ? 64'h7ff : 64'hFF_FFFF_FFFF)) | (dbl ? 64'h400 : 64'h80_0000_0000);
      case (pick)
        0: eo = -int'($urandom % 70);
        1: eo = em - 2 + int'($urandom % 4);
        2: eo = 1 + int'($urandom % 200);
        default: eo = 0;
      endcase
      send(mkop(1'($urandom), eo, dbl, m), 2'($urandom), 4'($urandom), dbl, 3'($urandom), "R3");
    end

    @(negedge clk);
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    check("R2", "drained", 64'(sb.size()), 64'd0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule